// File: doc/BRIEF.md
# Pause Frame Transmit Scheduler

This block decides when a full-duplex Ethernet MAC sends pause control frames. The host writes a 2-bit flow control mode and a 16-bit pause time. The block turns these into requests to a frame builder. Each request carries the pause time to advertise, either the programmed value or zero. A request is sent either once or again and again at a fixed interval. After a one-shot request has been served, the block sets the mode back to off by itself.

The block does not build frames or arbitrate with host packets. It raises a request with a value, holds both steady, and waits for a one-cycle grant from the frame builder. Host packets never pass through it.

The host reads back an 8-bit status word: the mode field, a copy of the MAC duplex setting and zeros above. When the MAC is in half-duplex the same mode codes only drive a flow-on level and never produce a frame.

Top module: `pause_tx_sched`

## Requirements
- R1: After reset the mode field is off (00) and `pauseReq` is low.
- R2: `statusRd` reads bits 1:0 = current mode, bit 2 = `fullDuplex`, bits 7:3 = 0.
- R3: Mode 01 (single pause) with full-duplex and `txPauseEn` high raises one request carrying the programmed pause value. The mode then returns to 00 on the grant, and no further request follows.
- R4: Mode 11 (final pause) raises one request whose `pauseValue` is 0000h, then returns the mode to 00 on the grant.
- R5: Mode 10 (periodic) requests a frame at the first decision after the mode is entered. After each grant it waits for (pause value >> 1) pulses of `quantaTick` before the next request. This repeats for as long as mode 10 is held.
- R6: Once `pauseReq` is raised, it stays high and `pauseValue` stays stable until a cycle with `pauseGnt` high. That cycle ends the request.
- R7: No request is raised while `fullDuplex` or `txPauseEn` is low. A pending mode 01 or 11 is kept until both are high.
- R8: `hdFlowOn` is high only when `fullDuplex` is low and mode bit 0 is 1 (codes 01 and 11).
- R9: A mode write during an outstanding request leaves that request and its value unchanged. The new mode is used at the next decision, and it is not cleared by the grant of the earlier one-shot request.
- R10: Mode 00 never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Host write strobe for the mode field |
| cfgWrMode | input | 2 | Mode code written by the host |
| pauseValWrEn | input | 1 | Host write strobe for the pause value |
| pauseValWrData | input | 16 | Pause time in 512-bit-time quanta |
| fullDuplex | input | 1 | MAC duplex setting, 1 = full-duplex |
| txPauseEn | input | 1 | Permission to transmit pause frames |
| quantaTick | input | 1 | One pulse per 512 bit times |
| pauseGnt | input | 1 | Frame builder accepted and sent the requested frame |
| pauseReq | output | 1 | Request to send a pause frame |
| pauseValue | output | 16 | Pause time to place in the requested frame |
| statusRd | output | 8 | Read-only status word |
| hdFlowOn | output | 1 | Half-duplex flow control on level |

## Verification
The checker watches four things on every cycle. First, it checks the request handshake: the request and its value must hold until the grant. Second, it checks that a request rises only while full-duplex and transmit-pause permission were both present. Third, it checks that a request never rises out of mode 00, and that one rising out of mode 11 carries zero. Fourth, it checks that the half-duplex flow level appears only in half-duplex.

Only the directed scenarios can show the longer-range behaviour. This covers the return to off after a one-shot request, the exact number of quanta between periodic frames, a held one-shot code waiting for permission, and a mode rewritten during an outstanding request that must survive that request's grant.

// File: rtl/pause_tx_pkg.sv
package pause_tx_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF       = 2'b00,
    MODE_ONCE      = 2'b01,
    MODE_PERIODIC  = 2'b10,
    MODE_ONCE_ZERO = 2'b11
  } fcMode_e;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic issue;      // capture a new outgoing pause value
    logic zeroVal;    // captured value is forced to zero
    logic reloadCnt;  // restart the periodic interval counter
    logic clearMode;  // hardware return of the mode field to off
  } ctrlStrobe_t;

endpackage

// File: rtl/pause_tx_dp.sv
module pause_tx_dp
  import pause_tx_pkg::*;
#(
  parameter int VAL_W        = 16,
  parameter int STATUS_W     = 8,
  parameter int RELOAD_SHIFT = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [MODE_W-1:0]   cfgWrMode,
  input  logic                pauseValWrEn,
  input  logic [VAL_W-1:0]    pauseValWrData,
  input  logic                fullDuplex,
  input  logic                quantaTick,
  input  ctrlStrobe_t         strobe,
  output fcMode_e             mode,
  output logic                cntZero,
  output logic [VAL_W-1:0]    pauseValue,
  output logic [STATUS_W-1:0] statusRd
);

  localparam int DUPLEX_BIT = MODE_W;

  logic [VAL_W-1:0] pauseValReg;
  logic [VAL_W-1:0] intervalCnt;
  logic [VAL_W-1:0] outVal;

  // Host mode field; host writes win over the hardware clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= MODE_OFF;
    end else if (cfgWrEn) begin
      mode <= fcMode_e'(cfgWrMode);
    end else if (strobe.clearMode) begin
      mode <= MODE_OFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseValReg <= '0;
    end else if (pauseValWrEn) begin
      pauseValReg <= pauseValWrData;
    end
  end

  // Interval counter, only alive in periodic mode.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (mode != MODE_PERIODIC) begin
      intervalCnt <= '0;
    end else if (strobe.reloadCnt) begin
      intervalCnt <= pauseValReg >> RELOAD_SHIFT;
    end else if (quantaTick && (intervalCnt != '0)) begin
      intervalCnt <= intervalCnt - 1'b1;
    end
  end

  assign cntZero = (intervalCnt == '0);

  // Value presented with the request, frozen until the next issue.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outVal <= '0;
    end else if (strobe.issue) begin
      outVal <= strobe.zeroVal ? '0 : pauseValReg;
    end
  end

  assign pauseValue = outVal;

  always_comb begin
    statusRd                = '0;
    statusRd[MODE_W-1:0]    = mode;
    statusRd[DUPLEX_BIT]    = fullDuplex;
  end

endmodule

// File: rtl/pause_tx_ctrl.sv
module pause_tx_ctrl
  import pause_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        fullDuplex,
  input  logic        txPauseEn,
  input  logic        pauseGnt,
  input  fcMode_e     mode,
  input  logic        cntZero,
  output ctrlStrobe_t strobe,
  output logic        pauseReq,
  output logic        hdFlowOn
);

  logic    pending;
  fcMode_e launched;
  logic    allowed;
  logic    wantFrame;
  logic    issueNow;
  logic    served;
  logic    oneShot;

  assign allowed = fullDuplex && txPauseEn;

  always_comb begin
    unique case (mode)
      MODE_ONCE, MODE_ONCE_ZERO: wantFrame = 1'b1;
      MODE_PERIODIC:             wantFrame = cntZero;
      default:                   wantFrame = 1'b0;
    endcase
  end

  assign issueNow = !pending && allowed && wantFrame;
  assign served   = pending && pauseGnt;
  assign oneShot  = (launched == MODE_ONCE) || (launched == MODE_ONCE_ZERO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      launched <= MODE_OFF;
    end else if (issueNow) begin
      pending  <= 1'b1;
      launched <= mode;
    end else if (served) begin
      pending  <= 1'b0;
    end
  end

  always_comb begin
    strobe.issue     = issueNow;
    strobe.zeroVal   = (mode == MODE_ONCE_ZERO);
    strobe.reloadCnt = served && (launched == MODE_PERIODIC);
    // Clear only if the host has left the launching code in place.
    strobe.clearMode = served && oneShot && (mode == launched) && !cfgWrEn;
  end

  assign pauseReq = pending;
  assign hdFlowOn = !fullDuplex && mode[0];

endmodule

// File: rtl/pause_tx_sched.sv
module pause_tx_sched
  import pause_tx_pkg::*;
#(
  parameter int VAL_W        = 16,
  parameter int STATUS_W     = 8,
  parameter int RELOAD_SHIFT = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [1:0]          cfgWrMode,
  input  logic                pauseValWrEn,
  input  logic [VAL_W-1:0]    pauseValWrData,
  input  logic                fullDuplex,
  input  logic                txPauseEn,
  input  logic                quantaTick,
  input  logic                pauseGnt,
  output logic                pauseReq,
  output logic [VAL_W-1:0]    pauseValue,
  output logic [STATUS_W-1:0] statusRd,
  output logic                hdFlowOn
);

  ctrlStrobe_t strobe;
  fcMode_e     mode;
  logic        cntZero;

  pause_tx_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .fullDuplex (fullDuplex),
    .txPauseEn  (txPauseEn),
    .pauseGnt   (pauseGnt),
    .mode       (mode),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .pauseReq   (pauseReq),
    .hdFlowOn   (hdFlowOn)
  );

  pause_tx_dp #(
    .VAL_W        (VAL_W),
    .STATUS_W     (STATUS_W),
    .RELOAD_SHIFT (RELOAD_SHIFT)
  ) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .cfgWrEn        (cfgWrEn),
    .cfgWrMode      (cfgWrMode),
    .pauseValWrEn   (pauseValWrEn),
    .pauseValWrData (pauseValWrData),
    .fullDuplex     (fullDuplex),
    .quantaTick     (quantaTick),
    .strobe         (strobe),
    .mode           (mode),
    .cntZero        (cntZero),
    .pauseValue     (pauseValue),
    .statusRd       (statusRd)
  );

endmodule

// File: rtl/pause_tx_sched_chk.sv
module pause_tx_sched_chk #(
  parameter int VAL_W    = 16,
  parameter int STATUS_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                fullDuplex,
  input logic                txPauseEn,
  input logic                pauseGnt,
  input logic                pauseReq,
  input logic [VAL_W-1:0]    pauseValue,
  input logic [STATUS_W-1:0] statusRd,
  input logic                hdFlowOn
);

  // R6: request held until granted
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pauseReq && !pauseGnt) |=> pauseReq);

  // R6: value frozen while request waits
  assert_val_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pauseReq && !pauseGnt) |=> $stable(pauseValue));

  // R7: request only rises under permission
  assert_req_needs_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pauseReq) |-> $past(fullDuplex && txPauseEn));

  // R4: final pause carries zero
  assert_final_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pauseReq) && ($past(statusRd[1:0]) == 2'b11)) |-> (pauseValue == '0));

  // R10: mode off never launches a request
  assert_off_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pauseReq) |-> ($past(statusRd[1:0]) != 2'b00));

  // R8: flow-on level only in half-duplex
  assert_hd_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    hdFlowOn |-> !fullDuplex);

endmodule

bind pause_tx_sched pause_tx_sched_chk #(
  .VAL_W    (VAL_W),
  .STATUS_W (STATUS_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .fullDuplex (fullDuplex),
  .txPauseEn  (txPauseEn),
  .pauseGnt   (pauseGnt),
  .pauseReq   (pauseReq),
  .pauseValue (pauseValue),
  .statusRd   (statusRd),
  .hdFlowOn   (hdFlowOn)
);

// File: tb/pause_tx_sched_tb.sv
module pause_tx_sched_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [1:0]  cfgWrMode;
  logic        pauseValWrEn;
  logic [15:0] pauseValWrData;
  logic        fullDuplex;
  logic        txPauseEn;
  logic        quantaTick;
  logic        pauseGnt;
  logic        pauseReq;
  logic [15:0] pauseValue;
  logic [7:0]  statusRd;
  logic        hdFlowOn;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pause_tx_sched dut_i (
    .clk            (clk),
    .rstN           (rstN),
    .cfgWrEn        (cfgWrEn),
    .cfgWrMode      (cfgWrMode),
    .pauseValWrEn   (pauseValWrEn),
    .pauseValWrData (pauseValWrData),
    .fullDuplex     (fullDuplex),
    .txPauseEn      (txPauseEn),
    .quantaTick     (quantaTick),
    .pauseGnt       (pauseGnt),
    .pauseReq       (pauseReq),
    .pauseValue     (pauseValue),
    .statusRd       (statusRd),
    .hdFlowOn       (hdFlowOn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostMode(input logic [1:0] m);
    cfgWrEn = 1'b1; cfgWrMode = m;
    cyc(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic hostVal(input logic [15:0] v);
    pauseValWrEn = 1'b1; pauseValWrData = v;
    cyc(1);
    pauseValWrEn = 1'b0;
  endtask

  task automatic grant();
    pauseGnt = 1'b1;
    cyc(1);
    pauseGnt = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      quantaTick = 1'b1; cyc(1);
      quantaTick = 1'b0; cyc(1);
    end
  endtask

  task automatic tReset();
    check("R1 req after reset", pauseReq, 0);
    check("R1 R2 status after reset", statusRd, 8'h04);
    check("R8 no flow level in full duplex", hdFlowOn, 0);
  endtask

  task automatic tSingle();
    hostVal(16'h1234);
    hostMode(2'b01);
    check("R2 status shows mode 01", statusRd, 8'h05);
    cyc(1);
    check("R3 request raised", pauseReq, 1);
    check("R3 value is programmed", pauseValue, 16'h1234);
    cyc(3);
    check("R6 request still held", pauseReq, 1);
    check("R6 value still held", pauseValue, 16'h1234);
    grant();
    check("R3 request dropped on grant", pauseReq, 0);
    check("R3 mode back to off", statusRd, 8'h04);
    cyc(6);
    check("R3 no second request", pauseReq, 0);
  endtask

  task automatic tFinal();
    hostMode(2'b11);
    cyc(1);
    check("R4 request raised", pauseReq, 1);
    check("R4 value is zero", pauseValue, 0);
    grant();
    check("R4 mode back to off", statusRd, 8'h04);
    cyc(4);
    check("R4 no second request", pauseReq, 0);
  endtask

  task automatic tPeriodic();
    hostVal(16'd8);
    hostMode(2'b10);
    cyc(1);
    check("R5 first request at once", pauseReq, 1);
    check("R5 value programmed", pauseValue, 16'd8);
    grant();
    check("R5 request dropped", pauseReq, 0);
    check("R5 mode held", statusRd, 8'h06);
    ticks(3);
    check("R5 no request before 4 quanta", pauseReq, 0);
    ticks(1);
    check("R5 second request after 4 quanta", pauseReq, 1);
    // R9: switch off while this frame is outstanding
    hostMode(2'b00);
    check("R9 request kept across write", pauseReq, 1);
    check("R9 value kept across write", pauseValue, 16'd8);
    grant();
    ticks(6);
    check("R9 R10 no request after switch to off", pauseReq, 0);
  endtask

  task automatic tHalfDuplex();
    fullDuplex = 1'b0;
    hostMode(2'b01);
    check("R2 duplex bit clear", statusRd, 8'h01);
    check("R8 flow on for 01", hdFlowOn, 1);
    cyc(5);
    check("R7 no request in half duplex", pauseReq, 0);
    hostMode(2'b10);
    check("R8 flow off for 10", hdFlowOn, 0);
    ticks(2);
    check("R7 no periodic request in half duplex", pauseReq, 0);
    hostMode(2'b11);
    check("R8 flow on for 11", hdFlowOn, 1);
    hostMode(2'b00);
    check("R8 flow off for 00", hdFlowOn, 0);
    fullDuplex = 1'b1;
    cyc(1);
  endtask

  task automatic tNoPermission();
    txPauseEn = 1'b0;
    hostVal(16'h00AA);
    hostMode(2'b01);
    cyc(5);
    check("R7 no request without permission", pauseReq, 0);
    check("R7 one-shot mode retained", statusRd, 8'h05);
    txPauseEn = 1'b1;
    cyc(1);
    check("R7 request once permitted", pauseReq, 1);
    check("R7 value once permitted", pauseValue, 16'h00AA);
    grant();
    check("R7 mode cleared after grant", statusRd, 8'h04);
  endtask

  task automatic tRewrite();
    hostVal(16'h5555);
    hostMode(2'b01);
    cyc(1);
    check("R9 first request", pauseValue, 16'h5555);
    hostMode(2'b11);
    check("R9 value unchanged by write", pauseValue, 16'h5555);
    grant();
    check("R9 new mode survives grant", statusRd, 8'h07);
    cyc(1);
    check("R9 new mode issues next", pauseReq, 1);
    check("R9 next value zero", pauseValue, 0);
    grant();
    check("R9 mode off at end", statusRd, 8'h04);
  endtask

  task automatic tOff();
    ticks(10);
    cyc(10);
    check("R10 no request in mode 00", pauseReq, 0);
  endtask

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgWrMode = 2'b00;
    pauseValWrEn = 1'b0; pauseValWrData = '0;
    fullDuplex = 1'b1; txPauseEn = 1'b1;
    quantaTick = 1'b0; pauseGnt = 1'b0;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    tReset();
    tSingle();
    tFinal();
    tPeriodic();
    tHalfDuplex();
    tNoPermission();
    tRewrite();
    tOff();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule